// File: doc/BRIEF.md
# Byte-Exchange SPI Master with Register Interface

This block is an SPI master that a processor drives through a small 32-bit register window. Software programs a clock setting and a bus mode, sets the enable bit, and writes one byte to the transmit slot. The block then drops its chip select, runs eight SCK cycles and shifts a byte out on MOSI while it captures a byte from MISO. When the exchange ends, the captured byte sits in the receive slot and a flag reports it. The exchange is always full duplex. To read from a slave, software sends a dummy byte.

The SCK rate comes from two stages. The first is a fixed prescale of 16 or 128, chosen by one control bit. The second is an even divide by 2×(N+1), where N is a 5-bit field. Clock polarity and clock phase are separate control bits, so all four SPI modes are available. Software polls a busy bit before it writes the next byte. It polls a receive-full flag before it reads the result.

The register port is a plain single-cycle strobe interface: a write takes effect at the clock edge where `reg_wr` is high, and read data is combinational. Nothing can stall the bus, so there is no back-pressure and no valid/ready pair.

Top module: `spim_regctl`

## Requirements
- R1: Offset 0x00 (control) stores bits [7:0] of a write and reads them back with bits [31:8] as 0. Offset 0x14 is 32-bit read/write storage. Offset 0x08 bit 0 is the master-enable bit and reads back. Offset 0x0C reads 0.
- R2: While a byte is moving, SCK changes level every P×(N+1) clock cycles. N is control[4:0]. P is 128 when control[5]=1 and 16 when control[5]=0. The first change comes P×(N+1) cycles after the cycle that accepted the transmit write.
- R3: A write to 0x0C starts an exchange only when master-enable is 1 and no exchange is in progress. The byte written is wdata[7:0]. A write with master-enable at 0 leaves CS and SCK idle.
- R4: SCK rests at the CPOL level, control bit 6, whenever CS is high. An exchange produces exactly 16 SCK transitions.
- R5: MOSI sends the byte MSB first. With CPHA (control bit 7) at 0, each bit is on MOSI before the leading edge of its cycle and changes on the trailing edge. With CPHA at 1, a new bit appears on each leading edge after the first one.
- R6: MISO is sampled on leading edges when CPHA=0 and on trailing edges when CPHA=1. The assembled byte, MSB first, reads from offset 0x10 with bits [31:8] as 0.
- R7: CS (active low) and status bit 0 (busy) are both asserted from the cycle after the accepted transmit write through the cycle of the 16th SCK transition. Both release together.
- R8: Status bit 2 (receive full) sets when an exchange completes. It clears on a read of 0x10, or on a write to 0x04 with bit 2 at 0. If completion and clearing happen in the same cycle, completion wins.
- R9: A transmit write during an exchange has no effect. The current byte finishes unchanged and no second exchange follows.
- R10: After reset, every register reads 0, CS is high and SCK is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (has the side effects of a read) |
| reg_addr | input | 5 | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| sck | output | 1 | SPI serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the slave |
| miso | input | 1 | Serial data from the slave |

## Verification
A wrong edge counter or phase bit shows up on SCK within one half-period: there is one transition too many or too few, or a wrong idle level once CS releases. A shift register that moves on the wrong edge puts a wrong MOSI bit on the line in the very half-period where it happens. Sampling MISO on the wrong edge picks up the slave's next bit, so the byte in the receive slot is wrong as soon as the exchange ends. A flag that is not cleared or set correctly shows on the next status read.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int REG_AW = 5;

  localparam logic [REG_AW-1:0] OFF_CTRL  = 5'h00;
  localparam logic [REG_AW-1:0] OFF_STAT  = 5'h04;
  localparam logic [REG_AW-1:0] OFF_SYS   = 5'h08;
  localparam logic [REG_AW-1:0] OFF_TX    = 5'h0C;
  localparam logic [REG_AW-1:0] OFF_RX    = 5'h10;
  localparam logic [REG_AW-1:0] OFF_CTRL2 = 5'h14;

  localparam int DIV_W = 5;

  // bit positions match the control register layout
  typedef struct packed {
    logic             cpha;    // bit 7
    logic             cpol;    // bit 6
    logic             pre_hi;  // bit 5
    logic [DIV_W-1:0] div_n;   // bits 4:0
  } ctrl_t;
endpackage

// File: rtl/spim_sckgen.sv
module spim_sckgen #(
  parameter int PRE_LO_LOG2 = 4,
  parameter int PRE_HI_LOG2 = 7,
  parameter int DIV_W       = 5,
  parameter int EDGES       = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic             pre_hi,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick,
  output logic             last,
  output logic             phase,
  output logic [$clog2(EDGES)-1:0] idx
);
  localparam int CNT_W = PRE_HI_LOG2 + DIV_W + 1;
  localparam int IDX_W = $clog2(EDGES);

  logic [CNT_W-1:0] cnt_q, base, half;

  assign base = CNT_W'(div_n) + CNT_W'(1);
  assign half = pre_hi ? (base << PRE_HI_LOG2) : (base << PRE_LO_LOG2);
  assign tick = run && (cnt_q == half - CNT_W'(1));
  assign last = tick && (idx == IDX_W'(EDGES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      idx   <= '0;
      phase <= 1'b0;
    end else if (start) begin
      cnt_q <= '0;
      idx   <= '0;
      phase <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      idx   <= idx + IDX_W'(1);
      phase <= ~phase;
    end else if (run) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int BITS  = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [BITS-1:0]  load,
  input  logic             tick,
  input  logic [IDX_W-1:0] idx,
  input  logic             cpha,
  input  logic             miso,
  output logic             mosi,
  output logic [BITS-1:0]  rx_final
);
  logic [BITS-1:0] tx_sh, rx_sh, rx_next;
  logic lead, do_sample, do_shift;

  assign lead      = ~idx[0];
  assign do_sample = cpha ? ~lead : lead;
  assign do_shift  = cpha ? (lead && (idx != '0)) : ~lead;
  assign rx_next   = {rx_sh[BITS-2:0], miso};
  assign rx_final  = do_sample ? rx_next : rx_sh;
  assign mosi      = tx_sh[BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
    end else if (start) begin
      tx_sh <= load;
      rx_sh <= '0;
    end else if (tick) begin
      if (do_sample) rx_sh <= rx_next;
      if (do_shift)  tx_sh <= tx_sh << 1;
    end
  end
endmodule

// File: rtl/spim_regctl.sv
module spim_regctl
  import spim_pkg::*;
#(
  parameter int BITS        = 8,
  parameter int PRE_LO_LOG2 = 4,
  parameter int PRE_HI_LOG2 = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int EDGES = 2 * BITS;
  localparam int IDX_W = $clog2(EDGES);

  ctrl_t           ctrl_q;
  logic [31:0]     ctrl2_q;
  logic            master_q, busy_q, rxfull_q;
  logic [BITS-1:0] rxbuf_q, rx_final;
  logic            start, tick, last, phase;
  logic            rx_clear;
  logic [IDX_W-1:0] idx;

  assign start    = reg_wr && (reg_addr == OFF_TX) && !busy_q && master_q;
  assign rx_clear = (reg_rd && (reg_addr == OFF_RX)) ||
                    (reg_wr && (reg_addr == OFF_STAT) && !reg_wdata[2]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      ctrl2_q  <= '0;
      master_q <= 1'b0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFF_CTRL:  ctrl_q   <= ctrl_t'(reg_wdata[7:0]);
        OFF_SYS:   master_q <= reg_wdata[0];
        OFF_CTRL2: ctrl2_q  <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      rxfull_q <= 1'b0;
      rxbuf_q  <= '0;
    end else begin
      if (start)     busy_q <= 1'b1;
      else if (last) busy_q <= 1'b0;
      if (last) begin
        rxbuf_q  <= rx_final;
        rxfull_q <= 1'b1;
      end else if (rx_clear) begin
        rxfull_q <= 1'b0;
      end
    end
  end

  spim_sckgen #(
    .PRE_LO_LOG2(PRE_LO_LOG2), .PRE_HI_LOG2(PRE_HI_LOG2),
    .DIV_W(DIV_W), .EDGES(EDGES)
  ) u_sckgen (
    .clk(clk), .rst_n(rst_n), .start(start), .run(busy_q),
    .pre_hi(ctrl_q.pre_hi), .div_n(ctrl_q.div_n),
    .tick(tick), .last(last), .phase(phase), .idx(idx)
  );

  spim_shifter #(.BITS(BITS), .IDX_W(IDX_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .start(start), .load(reg_wdata[BITS-1:0]),
    .tick(tick), .idx(idx), .cpha(ctrl_q.cpha), .miso(miso),
    .mosi(mosi), .rx_final(rx_final)
  );

  assign sck  = ctrl_q.cpol ^ phase;
  assign cs_n = ~busy_q;

  always_comb begin
    case (reg_addr)
      OFF_CTRL:  reg_rdata = {24'd0, ctrl_q};
      OFF_STAT:  reg_rdata = {29'd0, rxfull_q, 1'b0, busy_q};
      OFF_SYS:   reg_rdata = {31'd0, master_q};
      OFF_RX:    reg_rdata = {{(32-BITS){1'b0}}, rxbuf_q};
      OFF_CTRL2: reg_rdata = ctrl2_q;
      default:   reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spim_regctl_chk.sv
module spim_regctl_chk
  import spim_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_AW-1:0] reg_addr,
  input logic              sck,
  input logic              cs_n,
  input logic              mosi,
  input logic              busy,
  input logic              rxfull,
  input logic              master,
  input logic              cpol
);
  assert_sck_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sck == cpol));

  assert_start_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_TX && !busy && master) |=> !cs_n);

  assert_no_start_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_TX && !busy && !master) |=> cs_n);

  assert_rxfull_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rxfull) |-> $fell(busy));

  assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFF_RX && !busy) |=> !rxfull);

  assert_mosi_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && $stable(sck)) |-> $stable(mosi));
endmodule

bind spim_regctl spim_regctl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .sck(sck), .cs_n(cs_n), .mosi(mosi),
  .busy(busy_q), .rxfull(rxfull_q), .master(master_q), .cpol(ctrl_q.cpol)
);

// File: tb/spim_regctl_tb_top.sv
module spim_regctl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic sck, cs_n, mosi, miso;

  int vectors = 0, errors = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  spim_regctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  // ---------------- reference model ----------------
  logic [7:0]  m_ctrl, m_tx, m_rxbuf, slv_byte;
  logic [31:0] m_ctrl2;
  logic        m_master, m_busy, m_rxfull;
  int          m_cnt, m_e;

  function automatic int m_half();
    return ((int'(m_ctrl[4:0])) + 1) * (m_ctrl[5] ? 128 : 16);
  endfunction

  function automatic int m_samples();
    return m_ctrl[7] ? (m_e / 2) : ((m_e + 1) / 2);
  endfunction

  function automatic int m_shifts();
    int lead_cnt;
    if (!m_ctrl[7]) return m_e / 2;
    lead_cnt = (m_e + 1) / 2;
    return (lead_cnt > 0) ? lead_cnt - 1 : 0;
  endfunction

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      5'h00: return {24'd0, m_ctrl};
      5'h04: return {29'd0, m_rxfull, 1'b0, m_busy};
      5'h08: return {31'd0, m_master};
      5'h10: return {24'd0, m_rxbuf};
      5'h14: return m_ctrl2;
      default: return 32'd0;
    endcase
  endfunction

  always_comb begin
    int s;
    s = m_samples();
    miso = (m_busy && s < 8) ? slv_byte[7 - s] : 1'b0;
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_tx <= '0; m_rxbuf <= '0; m_ctrl2 <= '0;
      m_master <= 0; m_busy <= 0; m_rxfull <= 0; m_cnt <= 0; m_e <= 0;
    end else begin
      bit fin;
      fin = m_busy && (m_cnt == m_half() - 1) && (m_e == 15);
      if (reg_wr) begin
        if (reg_addr == 5'h00) m_ctrl <= reg_wdata[7:0];
        if (reg_addr == 5'h08) m_master <= reg_wdata[0];
        if (reg_addr == 5'h14) m_ctrl2 <= reg_wdata;
      end
      if (m_busy) begin
        if (m_cnt == m_half() - 1) begin
          m_cnt <= 0;
          m_e   <= m_e + 1;
          if (m_e == 15) begin
            m_busy <= 0; m_rxbuf <= slv_byte; m_rxfull <= 1;
          end
        end else m_cnt <= m_cnt + 1;
      end else if (reg_wr && reg_addr == 5'h0C && m_master) begin
        m_busy <= 1; m_cnt <= 0; m_e <= 0; m_tx <= reg_wdata[7:0];
      end
      if (!fin && ((reg_rd && reg_addr == 5'h10) ||
                   (reg_wr && reg_addr == 5'h04 && !reg_wdata[2])))
        m_rxfull <= 0;
    end
  end

  // ---------------- checking ----------------
  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      #1;
      check("R7 cs_n", {31'd0, cs_n}, {31'd0, !m_busy});
      check("R4 sck", {31'd0, sck}, {31'd0, m_ctrl[6] ^ (m_busy ? m_e[0] : 1'b0)});
      if (m_busy) check("R5 mosi", {31'd0, mosi}, {31'd0, m_tx[7 - m_shifts()]});
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, input string tag);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 check(tag, reg_rdata, m_read(a));
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wait_idle();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  task automatic xfer(input logic [7:0] ctl, input logic [7:0] tx, input logic [7:0] sl,
                      input bool_busy_poke);
    int n;
    wr(5'h00, {24'd0, ctl});
    slv_byte = sl;
    wr(5'h0C, {24'd0, tx});
    // R2: cycles to the first SCK transition
    n = 0;
    while (sck == ctl[6] && n < 5000) begin @(negedge clk); n++; end
    check("R2 first edge delay", n, ((int'(ctl[4:0])) + 1) * (ctl[5] ? 128 : 16));
    if (bool_busy_poke) begin
      wr(5'h0C, 32'h0000_00C3);                       // R9: ignored while busy
      rd(5'h04, "R7 busy during exchange");
    end
    wait_idle();
    repeat (4) @(negedge clk);
    check("R9 no second exchange", {31'd0, cs_n}, 32'd1);
    rd(5'h04, "R8 rxfull after exchange");
    check("R6 rx byte model", {24'd0, m_rxbuf}, {24'd0, sl});
    rd(5'h10, "R6 rx buffer read");
    rd(5'h04, "R8 rxfull cleared by read");
  endtask

  typedef bit bool_busy_poke;

  initial begin
    repeat (200000) @(posedge clk);
    vectors++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    slv_byte = 8'h00;
    repeat (5) @(negedge clk);
    #1;
    check("R10 cs_n at reset", {31'd0, cs_n}, 32'd1);
    check("R10 sck at reset", {31'd0, sck}, 32'd0);
    rst_n = 1;
    rd(5'h00, "R10 ctrl reset");
    rd(5'h04, "R10 status reset");
    rd(5'h08, "R10 sys reset");
    rd(5'h10, "R10 rx reset");
    rd(5'h14, "R10 ctrl2 reset");

    wr(5'h14, 32'hA5C3_1E77);
    rd(5'h14, "R1 ctrl2 storage");
    wr(5'h00, 32'hFFFF_FF3F);
    rd(5'h00, "R1 ctrl low byte only");
    rd(5'h0C, "R1 tx reads zero");

    wr(5'h00, 32'h0000_0000);
    wr(5'h0C, 32'h0000_005A);                          // R3: master disabled
    repeat (20) @(negedge clk);
    check("R3 disabled write no CS", {31'd0, cs_n}, 32'd1);
    rd(5'h04, "R3 disabled not busy");

    wr(5'h08, 32'h0000_0001);
    rd(5'h08, "R1 master enable");

    xfer(8'h00, 8'hA5, 8'h3C, 1);   // mode 0
    xfer(8'h40, 8'h96, 8'hC1, 0);   // CPOL=1
    xfer(8'h80, 8'h5B, 8'h7E, 1);   // CPHA=1
    xfer(8'hC3, 8'hE1, 8'h81, 0);   // CPOL=1 CPHA=1, N=3
    xfer(8'h21, 8'h0F, 8'hF0, 0);   // prescale 128, N=1

    // R8: clear through a status write with bit 2 at 0
    slv_byte = 8'h99;
    wr(5'h0C, 32'h0000_0011);
    wait_idle();
    rd(5'h04, "R8 rxfull set");
    wr(5'h04, 32'h0000_0000);
    rd(5'h04, "R8 rxfull cleared by status write");
    rd(5'h10, "R6 rx byte 0x99");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule